// File: doc/BRIEF.md
# Measurement Channel Sequencer

This block runs a shared 8-bit successive-approximation converter over five analog channels. Without pause it steps through a fixed main sequence: battery, boost, temperature, boost. Boost is sampled twice as often as the other two channels. For each conversion the block sets the analog mux select and issues a one-cycle start strobe. It then waits for the converter's done pulse and stores the result in a small bank of result registers.

The two LED-string voltages are measured on demand. A falling edge on a string's enable control raises a request for that string. The request is served by an extra conversion inserted at the next interrupt point, which is the moment a boost conversion completes. A conversion that is already running always finishes first. Each interrupt point serves at most one string. When both strings are waiting, an alternating priority flag picks the winner. A programmable count of main sequences can force an LED conversion when no edge arrives. A conversion taken while the string is enabled also updates a separate on-state register for that string.

A host reads any result through a registered read port. Reads never stall or change the sequence.

Top module: `meas_sequencer`

## Requirements
- R1: In the cycles after reset is released, every result register reads 0, `conv_start` is low, the priority flag points to LED string 1, and the first conversion uses mux code 0 (battery). `conv_start` is high for exactly one cycle per conversion, and `mux_sel` does not change between that strobe and the matching `conv_done`.
- R2: Main conversions use mux codes in the repeating order 0 (battery), 1 (boost), 2 (temperature), 1 (boost). The next `conv_start` is high exactly two clock cycles after the cycle in which `conv_done` was high.
- R3: A falling edge on `led_en[0]` or `led_en[1]`, seen between two consecutive clock edges, raises a request for that string. At the next permitted interrupt point the request is served by a conversion with mux code 3 (LED 1) or 4 (LED 2). An interrupt point is the completion of a boost conversion. After the LED conversion, the main sequence resumes at the slot that follows the boost slot.
- R4: When an LED conversion completes, its result is written to the plain register of that string (read address 3 or 4). If that string's `led_en` bit is high in the `conv_done` cycle, the result is also written to the on-state register (address 5 or 6). If the bit is low, the on-state register keeps its old value.
- R5: After an LED conversion, no further LED conversion starts until four main conversions have completed. A request that arrives at a blocked point stays pending.
- R6: When both strings have a pending request at an interrupt point, the string named by the priority flag is served. The flag toggles after every LED conversion, whatever the reason for that conversion.
- R7: Take N = `force_seq` and require N to be nonzero. A counter records completions of the last main slot (the second boost) since the last LED conversion or reset, saturating at 511. At an interrupt point where this counter, read before that point's own completion is added, has reached N, an LED conversion of the priority-flag string is inserted even with no request pending. When `force_seq` is 0, conversions are never forced.
- R8: `rd_data` returns, one cycle after `rd_addr`, the register at that address: 0 battery, 1 boost, 2 temperature, 3 LED 1, 4 LED 2, 5 LED 1 on-state, 6 LED 2 on-state, 7 always 0. A read shows a write only from the cycle after the write, and reads have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| led_en | input | 2 | Enable level of LED strings 1 and 2 |
| force_seq | input | 9 | Main sequences before a forced LED conversion; 0 turns forcing off |
| conv_done | input | 1 | One-cycle pulse from the converter: the result is valid |
| conv_data | input | 8 | Conversion result |
| rd_addr | input | 3 | Result register read address |
| conv_start | output | 1 | One-cycle conversion start strobe |
| mux_sel | output | 3 | Analog channel select: 0 battery, 1 boost, 2 temperature, 3 LED 1, 4 LED 2 |
| rd_data | output | 8 | Registered read data |

## Verification
The bench model predicts every strobe time, every mux code and every register value. It is tried first with no LED activity, which shows the main order and strobe timing alone. Then single falling edges arrive with the enable left low, and short low pulses arrive with the enable back high by conversion time; these two patterns separate the plain-only write from the dual write. Simultaneous falls on both strings show that the priority alternates. A burst of closely spaced falls shows that the four-conversion gap blocks a point while the request stays pending. Periods with no edges and a nonzero force count, then with the count set to zero, separate forced insertion from the disabled case.

// File: rtl/meas_pkg.sv
package meas_pkg;
  localparam int CH_W     = 3;
  localparam int MAIN_LEN = 4;
  localparam int SLOT_W   = 2;
  localparam int N_LED    = 2;
  localparam int N_CHAN   = 5;

  typedef enum logic [CH_W-1:0] {
    CH_VBAT = 3'd0,
    CH_VBST = 3'd1,
    CH_TEMP = 3'd2,
    CH_LED1 = 3'd3,
    CH_LED2 = 3'd4
  } chan_e;

  // main order: battery, boost, temperature, boost
  function automatic chan_e main_chan(input logic [SLOT_W-1:0] idx);
    case (idx)
      2'd0:    return CH_VBAT;
      2'd2:    return CH_TEMP;
      default: return CH_VBST;
    endcase
  endfunction

  function automatic chan_e led_chan(input logic idx);
    return idx ? CH_LED2 : CH_LED1;
  endfunction
endpackage

// File: rtl/meas_req_arb.sv
module meas_req_arb
  import meas_pkg::*;
#(
  parameter int FORCE_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LED-1:0]   led_en,
  input  logic [FORCE_W-1:0] force_seq,
  input  logic               main_done,
  input  logic               seq_end,
  input  logic               at_point,
  output logic               grant,
  output logic               grant_ch
);
  localparam int GAP_W = $clog2(MAIN_LEN + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(MAIN_LEN);
  localparam logic [GAP_W-1:0] GAP_OK   = GAP_W'(MAIN_LEN - 1);

  logic [N_LED-1:0]   en_q, pend, fall, clr;
  logic               prio, pick, force_due, allowed;
  logic [FORCE_W-1:0] seq_cnt;
  logic [GAP_W-1:0]   gap;

  always_comb begin
    fall      = en_q & ~led_en;
    force_due = (force_seq != '0) && (seq_cnt >= force_seq);
    // the completion happening now counts toward the gap
    allowed   = gap >= GAP_OK;
    case (pend)
      2'b01:   pick = 1'b0;
      2'b10:   pick = 1'b1;
      default: pick = prio;
    endcase
    grant    = at_point && allowed && ((|pend) || force_due);
    grant_ch = pick;
    clr      = '0;
    if (grant) clr[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pend    <= '0;
      prio    <= 1'b0;
      seq_cnt <= '0;
      gap     <= GAP_FULL;
    end else begin
      en_q <= led_en;
      pend <= (pend & ~clr) | fall;
      if (grant) begin
        prio    <= ~prio;
        gap     <= '0;
        seq_cnt <= '0;
      end else if (main_done) begin
        if (gap != GAP_FULL) gap <= gap + 1'b1;
        if (seq_end && seq_cnt != '1) seq_cnt <= seq_cnt + 1'b1;
      end
    end
  end

  // R6: the flag flips after every served LED conversion
  a_r6_prio_flip: assert property (@(posedge clk) disable iff (rst)
    grant |=> (prio != $past(prio)));

  // R7: nothing pending and forcing off means no insertion
  a_r7_no_force_when_zero: assert property (@(posedge clk) disable iff (rst)
    (force_seq == '0 && pend == '0) |-> !grant);

  // R3: a lone request is consumed when served
  a_r3_single_served: assert property (@(posedge clk) disable iff (rst)
    (grant && pend == 2'b01 && fall == 2'b00) |=> (pend == 2'b00));
endmodule

// File: rtl/meas_slot_fsm.sv
module meas_slot_fsm
  import meas_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_done,
  input  logic            grant,
  input  logic            grant_ch,
  output logic            conv_start,
  output logic [CH_W-1:0] mux_sel,
  output logic            main_done,
  output logic            seq_end,
  output logic            at_point,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_ch,
  output logic            led_active,
  output logic            led_idx
);
  typedef enum logic {ST_ISSUE, ST_WAIT} st_e;

  st_e               st;
  logic [SLOT_W-1:0] slot;
  chan_e             cur;

  always_comb begin
    cur       = led_active ? led_chan(led_idx) : main_chan(slot);
    wr_en     = (st == ST_WAIT) && conv_done;
    main_done = wr_en && !led_active;
    at_point  = main_done && (cur == CH_VBST);
    seq_end   = main_done && (slot == SLOT_W'(MAIN_LEN - 1));
    wr_ch     = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_ISSUE;
      slot       <= '0;
      led_active <= 1'b0;
      led_idx    <= 1'b0;
      conv_start <= 1'b0;
      mux_sel    <= '0;
    end else begin
      case (st)
        ST_ISSUE: begin
          conv_start <= 1'b1;
          mux_sel    <= cur;
          st         <= ST_WAIT;
        end
        default: begin
          conv_start <= 1'b0;
          if (conv_done) begin
            st <= ST_ISSUE;
            if (led_active) begin
              led_active <= 1'b0;
            end else begin
              slot <= (slot == SLOT_W'(MAIN_LEN - 1)) ? '0 : slot + 1'b1;
              if (grant) begin
                led_active <= 1'b1;
                led_idx    <= grant_ch;
              end
            end
          end
        end
      endcase
    end
  end

  // R1: start strobe lasts one cycle
  a_r1_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R1: select moves only together with a new start strobe
  a_r1_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(conv_start) |-> $stable(mux_sel));
endmodule

// File: rtl/meas_result_bank.sv
module meas_result_bank
  import meas_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_on,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int N_MAIN = N_CHAN;
  localparam int N_REG  = N_MAIN + N_LED;

  logic [DATA_W-1:0] plain_mem [N_MAIN];
  logic [DATA_W-1:0] on_mem    [N_LED];
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_MAIN; i++)
      if (rd_addr == ADDR_W'(i)) rd_word = plain_mem[i];
    for (int j = 0; j < N_LED; j++)
      if (rd_addr == ADDR_W'(N_MAIN + j)) rd_word = on_mem[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_MAIN; i++) plain_mem[i] <= '0;
      for (int j = 0; j < N_LED; j++)  on_mem[j]    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        for (int i = 0; i < N_MAIN; i++)
          if (wr_ch == CH_W'(i)) plain_mem[i] <= wr_data;
        if (wr_on)
          for (int j = 0; j < N_LED; j++)
            if (wr_ch == CH_W'(int'(CH_LED1) + j)) on_mem[j] <= wr_data;
      end
      rd_data <= rd_word;
    end
  end

  // R4: a conversion taken with the string disabled leaves on-state values alone
  a_r4_on_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_on) |=> ($stable(on_mem[0]) && $stable(on_mem[1])));

  // R8: addresses past the map read zero
  a_r8_unmapped: assert property (@(posedge clk) disable iff (rst)
    (32'(rd_addr) >= N_REG) |=> (rd_data == '0));
endmodule

// File: rtl/meas_sequencer.sv
module meas_sequencer
  import meas_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FORCE_W = 9,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         led_en,
  input  logic [FORCE_W-1:0] force_seq,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               conv_start,
  output logic [2:0]         mux_sel,
  output logic [DATA_W-1:0]  rd_data
);
  logic            grant, grant_ch;
  logic            main_done, seq_end, at_point, wr_en, led_active, led_idx, wr_on;
  logic [CH_W-1:0] wr_ch;

  meas_req_arb #(.FORCE_W(FORCE_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .led_en    (led_en),
    .force_seq (force_seq),
    .main_done (main_done),
    .seq_end   (seq_end),
    .at_point  (at_point),
    .grant     (grant),
    .grant_ch  (grant_ch)
  );

  meas_slot_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .grant      (grant),
    .grant_ch   (grant_ch),
    .conv_start (conv_start),
    .mux_sel    (mux_sel),
    .main_done  (main_done),
    .seq_end    (seq_end),
    .at_point   (at_point),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .led_active (led_active),
    .led_idx    (led_idx)
  );

  // enable level at the moment the result lands decides the dual write
  assign wr_on = led_active && led_en[led_idx];

  meas_result_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_on   (wr_on),
    .wr_data (conv_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_meas_sequencer.sv
module test_meas_sequencer;
  localparam int LAT   = 4;
  localparam int WATCH = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] led_en = 2'b00;
  logic [8:0] force_seq = 9'd0;
  logic       conv_done = 1'b0;
  logic [7:0] conv_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  wire        conv_start;
  wire  [2:0] mux_sel;
  wire  [7:0] rd_data;

  meas_sequencer i_meas_sequencer (
    .clk(clk), .rst(rst), .led_en(led_en), .force_seq(force_seq),
    .conv_done(conv_done), .conv_data(conv_data), .rd_addr(rd_addr),
    .conv_start(conv_start), .mux_sel(mux_sel), .rd_data(rd_data)
  );

  initial forever #10 clk = ~clk;

  // behavioural converter: result = channel code in the top bits plus a running count
  initial begin : stub
    int scyc;
    int done_at;
    int ctr;
    scyc = 0; done_at = -1; ctr = 0;
    forever begin
      @(posedge clk); #1;
      scyc++;
      conv_done = 1'b0;
      rd_addr = 3'((scyc * 3) % 8);
      if (rst) done_at = -1;
      else if (conv_start) done_at = scyc + LAT;
      else if (scyc == done_at) begin
        conv_done = 1'b1;
        conv_data = {mux_sel, 5'(ctr)};
        ctr++;
        done_at = -1;
      end
    end
  end

  // reference model state and counters
  int cyc = 0, checks = 0, failures = 0;
  int start_at = -10;
  bit was_rst = 1'b1;
  int exp_rd = 0;
  string rd_tag = "R8";
  int m_regs[8];
  int m_slot = 0, m_since = 4, m_seqs = 0, m_led = 0, exp_ch = 0;
  bit m_in_led = 1'b0, m_prio = 1'b0, seen_first = 1'b0, finish_req = 1'b0, finished = 1'b0;
  bit [1:0] m_pend = 2'b00, m_prev = 2'b00, t_fall;
  bit t_allowed, t_fdue;
  string ch_tag = "R1";
  int n_single = 0, n_both = 0, n_forced = 0, n_on = 0, n_blocked = 0;

  function automatic int main_of(int s);
    return (s == 0) ? 0 : (s == 2) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic wrap_up();
    chk(n_single > 0, "R3", n_single, 1, "single-request LED conversions seen");
    chk(n_on > 0, "R4", n_on, 1, "on-state writes seen");
    chk(n_blocked > 0, "R5", n_blocked, 1, "blocked interrupt points seen");
    chk(n_both > 0, "R6", n_both, 1, "dual-request arbitrations seen");
    chk(n_forced > 0, "R7", n_forced, 1, "forced conversions seen");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCH) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end else if (rst) begin
      for (int i = 0; i < 8; i++) m_regs[i] = 0;
      m_slot = 0; m_since = 4; m_seqs = 0; m_in_led = 1'b0; m_led = 0;
      m_pend = 2'b00; m_prev = 2'b00; m_prio = 1'b0; exp_ch = 0; ch_tag = "R1";
      exp_rd = 0; was_rst = 1'b1; start_at = -10;
      if (cyc == 3) begin
        chk(conv_start == 1'b0, "R1", conv_start, 0, "strobe low in reset");
        chk(rd_data == 8'd0, "R1", rd_data, 0, "read data zero in reset");
      end
    end else if (finish_req && !finished) begin
      finished = 1'b1;
      wrap_up();
    end else begin
      if (was_rst) begin start_at = cyc + 1; was_rst = 1'b0; end
      chk(rd_data == 8'(exp_rd), rd_tag, rd_data, exp_rd, "read port value");
      chk(conv_start == (cyc == start_at), "R2", conv_start, int'(cyc == start_at), "start strobe timing");
      if (conv_start) begin
        chk(mux_sel == 3'(exp_ch), ch_tag, mux_sel, exp_ch, "channel select");
        if (!seen_first) begin
          seen_first = 1'b1;
          chk(mux_sel == 3'd0, "R1", mux_sel, 0, "first channel after reset");
        end
      end
      exp_rd = (rd_addr == 3'd7) ? 0 : m_regs[rd_addr];
      rd_tag = (rd_addr == 3'd5 || rd_addr == 3'd6) ? "R4" : "R8";
      t_fall = m_prev & ~led_en;
      if (conv_done) begin
        m_regs[exp_ch] = int'(conv_data);
        if (exp_ch >= 3 && led_en[exp_ch-3]) begin
          m_regs[exp_ch+2] = int'(conv_data);
          n_on++;
        end
        if (m_in_led) begin
          m_in_led = 1'b0;
          ch_tag = (m_pend != 0) ? "R5" : "R2";
        end else begin
          t_allowed = (m_since + 1) >= 4;
          t_fdue = (force_seq != 0) && (m_seqs >= int'(force_seq));
          if (exp_ch == 1 && !t_allowed && m_pend != 0) n_blocked++;
          if (exp_ch == 1 && t_allowed && (m_pend != 0 || t_fdue)) begin
            if (m_pend == 2'b01) begin m_led = 0; n_single++; ch_tag = "R3"; end
            else if (m_pend == 2'b10) begin m_led = 1; n_single++; ch_tag = "R3"; end
            else if (m_pend == 2'b11) begin m_led = int'(m_prio); n_both++; ch_tag = "R6"; end
            else begin m_led = int'(m_prio); n_forced++; ch_tag = "R7"; end
            m_pend[m_led] = 1'b0;
            m_prio = ~m_prio;
            m_in_led = 1'b1;
            m_since = 0;
            m_seqs = 0;
          end else begin
            if (m_since < 4) m_since++;
            if (m_slot == 3 && m_seqs < 511) m_seqs++;
            ch_tag = (m_pend != 0) ? "R5" : "R2";
          end
          m_slot = (m_slot + 1) % 4;
        end
        exp_ch = m_in_led ? 3 + m_led : main_of(m_slot);
        start_at = cyc + 2;
      end
      m_pend = m_pend | t_fall;
      m_prev = led_en;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(120);                              // R2: main order only
    led_en = 2'b01; tick(50);
    led_en = 2'b00; tick(90);               // R3/R4: falls, stays low
    led_en = 2'b01; tick(20);
    led_en = 2'b00; tick(2);
    led_en = 2'b01; tick(90);               // R4: back high by conversion time
    led_en = 2'b10; tick(2);
    led_en = 2'b00; tick(2);
    led_en = 2'b10; tick(90);
    led_en = 2'b11; tick(10);
    led_en = 2'b00; tick(150);              // R6: both fall together
    led_en = 2'b11; tick(10);
    led_en = 2'b00; tick(150);              // R6: flag has flipped
    for (int k = 0; k < 8; k++) begin       // R5: closely spaced requests
      led_en = 2'b01; tick(2);
      led_en = 2'b00; tick(5);
    end
    tick(150);
    force_seq = 9'd2; tick(500);            // R7: forced insertion
    force_seq = 9'd1; tick(250);
    force_seq = 9'd0; tick(250);            // R7: forcing off
    finish_req = 1'b1;
  end
endmodule